// File: doc/BRIEF.md
# Step Attenuator Control Word Loader

This block is the digital front end of a six-step binary attenuator. It turns three kinds of external control, a three-wire serial port (data, shift clock, latch strobe), a six-bit parallel bus and a mode pin, into one registered attenuation word. Bit k of the word weighs 2^k half-decibels, so the word runs from 0 (least attenuation) to all ones (31.5 dB). Every control input is asynchronous to the block and is brought into the fast system clock domain through a synchronizer before any edge on it is detected.

The mode pin selects serial or parallel loading. In serial loading, data is shifted in while the latch strobe is low and committed on its rising edge. In parallel loading, a high latch level makes the word track the bus, and a low level freezes the word until the next rising edge captures the bus. The word also drives a one-cycle update strobe whenever it takes a new value, so that downstream switch drivers can sequence their change.

Top module: `step_atten_ctrl`

## Requirements
- R1: The synchronized mode input selects serial loading when 1 and parallel loading when 0; while reset is applied its synchronizer reads as serial.
- R2: The serial shift register is WORD_W (6) bits wide and takes the most significant bit first: after any number of shift clocks it holds the last six bits sent, the first of them at bit 5, and bit k of the word has a weight of 2^k x 0.5 dB.
- R3: A bit is shifted only on a rising shift-clock edge seen while the latch strobe is low; while the strobe is high, shift-clock and data activity leave the shift register unchanged.
- R4: In serial loading, a rising latch-strobe edge copies the shift register into the word; at all other times the word holds, and the parallel bus has no effect.
- R5: While reset is applied and just after it is released, the word is 6'h3F and the update strobe is 0; in serial loading it stays 6'h3F whatever the parallel bus holds.
- R6: In parallel loading with the latch strobe high, the word follows the parallel bus, including the bus value present when reset is released.
- R7: In parallel loading with the latch strobe low the word is frozen; a rising edge of the strobe captures the bus.
- R8: When reset is released in parallel loading with the latch strobe low, the word stays at 6'h3F.
- R9: Every control input passes through SYNC_STAGES (2) flops; a change on an input is visible on the word on the third rising system clock edge after it, and not on the second.
- R10: The update strobe is 1 for exactly the one cycle in which the word takes a value different from its previous one, and 0 otherwise, including when a load writes the value already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| latch_i | input | 1 | Latch strobe / parallel track enable, asynchronous |
| mode_ser_i | input | 1 | 1 = serial loading, 0 = parallel loading |
| par_word_i | input | 6 | Parallel attenuation bus, asynchronous |
| atten_o | output | 6 | Registered attenuation word, 0.5 dB per LSB |
| upd_o | output | 1 | One-cycle strobe on every change of atten_o |

## Verification
The serial path is driven with a full six-bit write, an eight-bit write whose first two bits must fall out of the register, a write equal to the held word, and shift-clock toggling with the strobe high, which separates correct bit order and gating from a register that shifts the wrong way or listens too often. The parallel path alternates between tracking and frozen phases with bus changes in each, so a design that mixes up the two latch levels or drops the capture edge shows a different word. Three reset releases, one for each loading style, tell the mode-dependent start values apart, and one bus change sampled on the second and third clock edge pins down the synchronizer latency.

// File: rtl/sac_pkg.sv
package sac_pkg;
   typedef enum logic [1:0] {
      LD_SERIAL  = 2'd0,
      LD_TRACK   = 2'd1,
      LD_FROZEN  = 2'd2
   } load_kind_e;

   function automatic load_kind_e load_kind(input logic ser_mode, input logic le_lvl);
      if (ser_mode)    return LD_SERIAL;
      else if (le_lvl) return LD_TRACK;
      else             return LD_FROZEN;
   endfunction
endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sac_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sac_sync: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sac_edge.sv
module sac_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= RST_VAL;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o); // R3
endmodule

// File: rtl/sac_shift.sv
module sac_shift #(
   parameter int WORD_W    = 6,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_mode_i,
   input  logic              le_lvl_i,
   input  logic              sclk_rise_i,
   input  logic              data_i,
   output logic [WORD_W-1:0] sh_o
);
   logic              shift_en;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_nxt;

   assign shift_en = ser_mode_i & ~le_lvl_i & sclk_rise_i;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("sac_shift: WORD_W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb_first
         assign sh_nxt = {sh_q[WORD_W-2:0], data_i};
      end else begin : g_lsb_first
         assign sh_nxt = {data_i, sh_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (shift_en) sh_q <= sh_nxt;
   end

   assign sh_o = sh_q;

   AST_SHIFT_GATED_BY_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_lvl_i |=> $stable(sh_q)); // R3

   AST_SHIFT_NO_CLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sclk_rise_i |=> $stable(sh_q)); // R3

   generate
      if (MSB_FIRST) begin : g_chk_msb
         AST_SHIFT_ENTRY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ser_mode_i && !le_lvl_i && sclk_rise_i) |=>
               (sh_q[0] == $past(data_i)) &&
               (sh_q[WORD_W-1:1] == $past(sh_q[WORD_W-2:0]))); // R2
      end
   endgenerate
endmodule

// File: rtl/sac_word.sv
module sac_word
   import sac_pkg::*;
#(
   parameter int WORD_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_mode_i,
   input  logic              le_lvl_i,
   input  logic              le_rise_i,
   input  logic [WORD_W-1:0] sh_i,
   input  logic [WORD_W-1:0] par_i,
   output logic [WORD_W-1:0] word_o,
   output logic              upd_o
);
   localparam logic [WORD_W-1:0] MAX_WORD = {WORD_W{1'b1}};

   load_kind_e        kind;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_nxt;
   logic              upd_q;

   assign kind = load_kind(ser_mode_i, le_lvl_i);

   always_comb begin
      word_nxt = word_q;
      unique case (kind)
         LD_SERIAL: if (le_rise_i) word_nxt = sh_i;
         LD_TRACK:  word_nxt = par_i;
         LD_FROZEN: word_nxt = word_q;
         default:   word_nxt = word_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= MAX_WORD;
         upd_q  <= 1'b0;
      end else begin
         word_q <= word_nxt;
         upd_q  <= (word_nxt != word_q);
      end
   end

   assign word_o = word_q;
   assign upd_o  = upd_q;

   AST_UPD_MATCHES_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (upd_q == (word_q != $past(word_q)))); // R10

   AST_SERIAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_mode_i && !le_rise_i) |=> $stable(word_q)); // R4

   AST_SERIAL_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_mode_i && le_rise_i) |=> (word_q == $past(sh_i))); // R4

   AST_TRACK_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_mode_i && le_lvl_i) |=> (word_q == $past(par_i))); // R6

   AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_mode_i && !le_lvl_i) |=> $stable(word_q)); // R7
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
   parameter int WORD_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_data_i,
   input  logic              ser_clk_i,
   input  logic              latch_i,
   input  logic              mode_ser_i,
   input  logic [WORD_W-1:0] par_word_i,
   output logic [WORD_W-1:0] atten_o,
   output logic              upd_o
);
   localparam int          CTL_W   = 4;
   localparam logic [CTL_W-1:0] CTL_RST = 4'b1100; // mode=serial, latch=high, clk=0, data=0

   logic [CTL_W-1:0]  ctl_raw;
   logic [CTL_W-1:0]  ctl_s;
   logic [WORD_W-1:0] par_s;
   logic              mode_s, le_s, sclk_s, data_s;
   logic              sclk_rise, le_rise;
   logic [WORD_W-1:0] sh_word;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("step_atten_ctrl: WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("step_atten_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   assign ctl_raw = {mode_ser_i, latch_i, ser_clk_i, ser_data_i};

   sac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ctl_raw), .q_o (ctl_s)
   );

   sac_sync #(.W(WORD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_par_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (par_word_i), .q_o (par_s)
   );

   assign {mode_s, le_s, sclk_s, data_s} = ctl_s;

   sac_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (sclk_s), .rise_o (sclk_rise)
   );

   sac_edge #(.RST_VAL(1'b1)) u_le_edge (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (le_s), .rise_o (le_rise)
   );

   sac_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ser_mode_i  (mode_s),
      .le_lvl_i    (le_s),
      .sclk_rise_i (sclk_rise),
      .data_i      (data_s),
      .sh_o        (sh_word)
   );

   sac_word #(.WORD_W(WORD_W)) u_word (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ser_mode_i (mode_s),
      .le_lvl_i   (le_s),
      .le_rise_i  (le_rise),
      .sh_i       (sh_word),
      .par_i      (par_s),
      .word_o     (atten_o),
      .upd_o      (upd_o)
   );

   AST_RESET_MAX: assert property (@(posedge clk_i)
      !rst_ni |=> (!rst_ni || (atten_o == {WORD_W{1'b1}}))); // R5

   AST_SER_IGNORES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_s && !le_rise) |=> $stable(atten_o)); // R1
endmodule

// File: tb/step_atten_ctrl_tb_top.sv
module step_atten_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sdata = 1'b0, sclk = 1'b0, latch = 1'b1, mode = 1'b1;
   logic [W-1:0] par = '0;
   logic [W-1:0] atten;
   logic         upd;

   int           n_checks = 0;
   int           n_fails  = 0;
   bit           done     = 1'b0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] model_word;
   logic [W-1:0] model_sh;

   always #(CLK_PERIOD/2) clk = ~clk;

   step_atten_ctrl dut_i (
      .clk_i (clk), .rst_ni (rst_n), .ser_data_i (sdata), .ser_clk_i (sclk),
      .latch_i (latch), .mode_ser_i (mode), .par_word_i (par),
      .atten_o (atten), .upd_o (upd)
   );

   // scoreboard monitor: every update strobe must match the next expected word (R10)
   always @(negedge clk) begin
      if (rst_n && upd) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fails++;
            $display("FAIL R10 unexpected update: actual %h expected no update", atten);
         end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            if (atten !== e) begin
               n_fails++;
               $display("FAIL R10 update value: actual %h expected %h", atten, e);
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_word(input logic [W-1:0] w);
      if (w != model_word) begin
         exp_q.push_back(w);
         model_word = w;
      end
   endtask

   task automatic check_word(input string req, input logic [W-1:0] e);
      wait_cyc(8);
      n_checks++;
      if (atten !== e || exp_q.size() != 0) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h (pending updates %0d)", req, atten, e, exp_q.size());
      end
   endtask

   task automatic shift_bits(input int nbits, input logic [15:0] bits);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdata = bits[i];
         wait_cyc(4);
         sclk = 1'b1;
         if (!latch && mode) model_sh = {model_sh[W-2:0], bits[i]};
         wait_cyc(4);
         sclk = 1'b0;
         wait_cyc(4);
      end
   endtask

   task automatic ser_write(input int nbits, input logic [15:0] bits);
      latch = 1'b0;
      wait_cyc(4);
      shift_bits(nbits, bits);
      latch = 1'b1;
      expect_word(model_sh);
      wait_cyc(4);
   endtask

   task automatic do_reset(input logic m, input logic l, input logic [W-1:0] p);
      rst_n = 1'b0;
      mode = m; latch = l; par = p; sclk = 1'b0; sdata = 1'b0;
      exp_q.delete();
      model_word = '1;
      model_sh   = '0;
      wait_cyc(4);
   endtask

   initial begin
      model_word = '1;
      model_sh   = '0;
      // R5: reset state in serial loading, bus holds a non-max value
      do_reset(1'b1, 1'b1, 6'h2A);
      n_checks++;
      if (atten !== 6'h3F || upd !== 1'b0) begin
         n_fails++;
         $display("FAIL R5 during reset: actual %h/%b expected 3f/0", atten, upd);
      end
      rst_n = 1'b1;
      check_word("R5 serial default ignores bus", 6'h3F);

      // R2/R4: plain six-bit write, MSB first
      ser_write(6, 16'b001011);
      check_word("R2 six-bit serial write", 6'h0B);
      // R2: eight bits, first two fall out
      ser_write(8, 16'b11100101);
      check_word("R2 last six bits kept", 6'h25);

      // R3: clocks and data while latch high are ignored
      shift_bits(6, 16'b111111);
      latch = 1'b0; wait_cyc(4); latch = 1'b1;
      check_word("R3 no shift while latch high", 6'h25);

      // R4: bus has no effect in serial loading
      par = 6'h3C;
      check_word("R4 bus ignored in serial", 6'h25);

      // R7: latched parallel freezes
      latch = 1'b0; wait_cyc(4);
      mode = 1'b0; wait_cyc(4);
      par = 6'h11;
      check_word("R7 frozen while latch low", 6'h25);
      latch = 1'b1;
      expect_word(6'h11);
      check_word("R7 capture on latch rise", 6'h11);

      // R9/R6: tracking with latency
      par = 6'h07;
      expect_word(6'h07);
      wait_cyc(2);
      n_checks++;
      if (atten !== 6'h11) begin
         n_fails++;
         $display("FAIL R9 changed too early: actual %h expected 11", atten);
      end
      wait_cyc(1);
      n_checks++;
      if (atten !== 6'h07) begin
         n_fails++;
         $display("FAIL R9 not changed on third edge: actual %h expected 07", atten);
      end
      check_word("R6 tracks bus", 6'h07);
      par = 6'h00;
      expect_word(6'h00);
      check_word("R6 tracks bus to minimum", 6'h00);

      latch = 1'b0; wait_cyc(4);
      par = 6'h2F;
      check_word("R7 frozen again", 6'h00);
      latch = 1'b1;
      expect_word(6'h2F);
      check_word("R7 second capture", 6'h2F);

      // R1: back to serial, word holds; equal-value write gives no strobe (R10)
      mode = 1'b1; wait_cyc(4);
      par = 6'h01;
      check_word("R1 serial selected, word held", 6'h2F);
      ser_write(6, 16'b101111);
      check_word("R10 same-value load no strobe", 6'h2F);

      // R6: startup in tracking parallel takes bus value
      do_reset(1'b0, 1'b1, 6'h15);
      exp_q.push_back(6'h15);
      model_word = 6'h15;
      rst_n = 1'b1;
      check_word("R6 tracking startup value", 6'h15);

      // R8: startup in frozen parallel stays max
      do_reset(1'b0, 1'b0, 6'h09);
      rst_n = 1'b1;
      check_word("R8 frozen startup at max", 6'h3F);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end
endmodule